// File: doc/BRIEF.md
# Management Command Portal with Alternating Response Slots

This block serves one management command at a time on behalf of software. Software writes the command into a 64-byte command register, one 32-bit word at a time. Writing word 0 with its top verb bit (the phase bit) flipped relative to the value held in the register commits the command. The block decodes the command, runs it against an external buffer-pool agent, and writes the outcome into one of two response slots. Successive commands land in alternating slots, so software can poll one slot's verb byte while the other still holds the previous answer.

Two commands exist: acquire, which takes up to eight buffers from one pool, and query. Any other verb, or an out-of-range pool id or count, yields an invalid-command response. An error flag on a pool grant yields an ECC-error response. A commit that arrives while a command is still running is dropped, and a sticky flag records the drop.

The pool side uses two valid/ready channels. On the request channel the block holds `pool_req_valid` and `pool_req_id` steady until `pool_req_ready` is seen. It never has more than one request outstanding. On the grant channel the block raises `pool_gnt_ready` only while it waits for the reply to its request. A grant counts only in a cycle where `pool_gnt_valid` and `pool_gnt_ready` are both high, and the agent must hold the grant until then.

Top module: `mgmt_cmd_portal`

## Requirements
- R1: After reset, word 0 of both response slots reads zero and `overrun` is low.
- R2: A write to command word 0 starts a command only when its bit 7 differs from bit 7 of the command verb the register holds. A write that keeps bit 7 unchanged starts nothing and changes no response.
- R3: With the command register at its reset value (bit 7 = 0), the first command completes into slot 1. Each later command goes to the other slot from the one before.
- R4: From the clock edge that accepts a command until that command completes, word 0 of its target slot reads zero. After completion, response word 0 holds {16'h0, pool byte, verb}, where verb bit 7 is the command's phase bit, bits 6:4 the result code and bits 3:0 the count.
- R5: Command word 0 holds verb in bits 7:0 and pool id in bits 15:8. Verb code 1 in bits 6:4 with count 1..8 in bits 3:0 is acquire. When the pool has enough buffers, the result code is 1, the count equals the request, buffer i sits in response word 1+i, and words past the count read zero.
- R6: If the pool runs out, acquire stops at the first empty reply and reports the number granted (0 when the pool was already empty). The unused words read zero.
- R7: A code other than 1 or 4, an acquire count of 0 or above 8, or a pool id above 63 gives result code 6 with count 0 and no pool request.
- R8: A grant with `pool_gnt_err` high ends the command with result code 7. The count is the number of buffers granted before the error.
- R9: Verb code 4 with a valid pool id is query. It gives result code 4, count 0, and the pool byte echoed, with no pool request.
- R10: A phase-flipping write to word 0 while a command is in progress is dropped entirely. `overrun` rises on the next edge and stays high until reset.
- R11: While a command runs and after it completes, the other slot keeps its earlier contents.
- R12: Each acquire issues one request per grant it consumes. A request stays valid and stable until accepted, and no request is raised while a grant is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register word write strobe |
| cmd_addr | input | 4 | Word index within the command register |
| cmd_wdata | input | 32 | Write data; word 0 carries verb and pool id |
| rsp_slot | input | 1 | Response slot to read |
| rsp_word | input | 4 | Response word to read (0 = header, 1..8 = buffers) |
| rsp_rdata | output | 32 | Read data, combinational |
| pool_req_valid | output | 1 | Buffer request to the pool agent |
| pool_req_ready | input | 1 | Pool agent accepts the request |
| pool_req_id | output | 6 | Pool addressed by the request |
| pool_gnt_valid | input | 1 | Grant reply present |
| pool_gnt_ready | output | 1 | Block is waiting for a grant |
| pool_gnt_empty | input | 1 | Reply says the pool is empty |
| pool_gnt_err | input | 1 | Reply carries an uncorrectable error |
| pool_gnt_addr | input | 32 | Granted buffer address |
| overrun | output | 1 | Sticky: a commit was dropped while busy |

## Verification
The bench targets a pool that runs dry partway through an acquire. A design that kept requesting after the empty reply would issue surplus requests, and one that miscounted would report the wrong count or leave stale addresses in the payload. It polls the target slot's header every clock, so a design that published the verb before the payload, or left the old verb visible after the commit, gets caught in the exact cycle. It sends a commit while a command is busy and a same-phase rewrite while idle. A design that honoured either would change the pool traffic, the command's echoed pool byte or the slot order. The counts 0 and 9 and pool id 64 are also sent, because a decoder that checked only the code field would issue pool requests for them.

// File: rtl/mcp_pkg.sv
`timescale 1ns/1ps
package mcp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} mcp_state_e;
  typedef enum logic [1:0] {K_ACQ, K_QRY, K_BAD} mcp_kind_e;
  localparam logic [2:0] OP_ACQ = 3'h1;
  localparam logic [2:0] OP_QRY = 3'h4;
  localparam logic [2:0] OP_BAD = 3'h6;
  localparam logic [2:0] OP_ECC = 3'h7;
endpackage

// File: rtl/mcp_decode.sv
`timescale 1ns/1ps
module mcp_decode
  import mcp_pkg::*;
#(
  parameter int MAX_BUF = 8,
  parameter int POOL_W  = 6
) (
  input  logic [7:0] verb,
  input  logic [7:0] pool_byte,
  output mcp_kind_e  kind,
  output logic [3:0] count
);
  logic [2:0] code;
  logic       pool_ok;

  assign code    = verb[6:4];
  assign count   = verb[3:0];
  assign pool_ok = (pool_byte >> POOL_W) == 8'h00;

  always_comb begin
    kind = K_BAD;
    if (code == OP_ACQ && count != 4'd0 && count <= 4'(MAX_BUF) && pool_ok)
      kind = K_ACQ;
    else if (code == OP_QRY && pool_ok)
      kind = K_QRY;
  end
endmodule

// File: rtl/mcp_slots.sv
`timescale 1ns/1ps
module mcp_slots #(
  parameter int ADDR_W  = 32,
  parameter int MAX_BUF = 8,
  parameter int WORD_W  = $clog2(MAX_BUF + 1),
  parameter int IDX_W   = (MAX_BUF > 1) ? $clog2(MAX_BUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_en,
  input  logic              clr_slot,
  input  logic              buf_we,
  input  logic              buf_slot,
  input  logic [IDX_W-1:0]  buf_idx,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic              fin_en,
  input  logic              fin_slot,
  input  logic [7:0]        fin_verb,
  input  logic [7:0]        fin_pool,
  input  logic              rd_slot,
  input  logic [WORD_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  output logic [1:0][7:0]   verb_o
);
  logic [1:0][7:0]   verb_q;
  logic [1:0][7:0]   pool_q;
  logic [ADDR_W-1:0] bufs [2][MAX_BUF];
  logic [IDX_W-1:0]  ridx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verb_q <= '0;
      pool_q <= '0;
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < MAX_BUF; b++)
          bufs[s][b] <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (clr_en && clr_slot == 1'(s)) begin
          verb_q[s] <= '0;
          pool_q[s] <= '0;
          for (int b = 0; b < MAX_BUF; b++)
            bufs[s][b] <= '0;
        end else begin
          if (buf_we && buf_slot == 1'(s))
            bufs[s][buf_idx] <= buf_addr;
          if (fin_en && fin_slot == 1'(s)) begin
            verb_q[s] <= fin_verb;
            pool_q[s] <= fin_pool;
          end
        end
      end
    end
  end

  assign ridx   = IDX_W'(rd_word - 1'b1);
  assign verb_o = verb_q;

  always_comb begin
    rd_data = '0;
    if (rd_word == '0)
      rd_data = {16'h0, pool_q[rd_slot], verb_q[rd_slot]};
    else if (rd_word <= WORD_W'(MAX_BUF))
      rd_data = 32'(bufs[rd_slot][ridx]);
  end
endmodule

// File: rtl/mgmt_cmd_portal.sv
`timescale 1ns/1ps
module mgmt_cmd_portal
  import mcp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int MAX_BUF = 8,
  parameter int POOL_W  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_we,
  input  logic [3:0]                     cmd_addr,
  input  logic [31:0]                    cmd_wdata,
  input  logic                           rsp_slot,
  input  logic [$clog2(MAX_BUF+1)-1:0]   rsp_word,
  output logic [31:0]                    rsp_rdata,
  output logic                           pool_req_valid,
  input  logic                           pool_req_ready,
  output logic [POOL_W-1:0]              pool_req_id,
  input  logic                           pool_gnt_valid,
  output logic                           pool_gnt_ready,
  input  logic                           pool_gnt_empty,
  input  logic                           pool_gnt_err,
  input  logic [ADDR_W-1:0]              pool_gnt_addr,
  output logic                           overrun
);
  localparam int WORD_W = $clog2(MAX_BUF + 1);
  localparam int IDX_W  = (MAX_BUF > 1) ? $clog2(MAX_BUF) : 1;
  localparam logic [7:0] CMD_RST_VERB = 8'h00;

  logic [7:0]        cmd_verb_q, cmd_pool_q;
  mcp_state_e        state_q;
  logic              slot_q;
  logic [WORD_W-1:0] cnt_q, need_q;
  logic [2:0]        code_q;
  logic              overrun_q;
  logic              busy, word0_wr, phase_flip, commit, take_buf;
  mcp_kind_e         dec_kind;
  logic [3:0]        dec_count;
  logic [1:0][7:0]   slot_verbs;
  logic              unused_hi;

  assign unused_hi  = ^cmd_wdata[31:16];
  assign busy       = (state_q != ST_IDLE);
  assign word0_wr   = cmd_we && (cmd_addr == 4'd0);
  assign phase_flip = word0_wr && (cmd_wdata[7] != cmd_verb_q[7]);
  assign commit     = phase_flip && !busy;
  assign take_buf   = (state_q == ST_WAIT) && pool_gnt_valid &&
                      !pool_gnt_err && !pool_gnt_empty;

  mcp_decode #(.MAX_BUF(MAX_BUF), .POOL_W(POOL_W)) u_dec (
    .verb      (cmd_wdata[7:0]),
    .pool_byte (cmd_wdata[15:8]),
    .kind      (dec_kind),
    .count     (dec_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_verb_q <= CMD_RST_VERB;
      cmd_pool_q <= '0;
      state_q    <= ST_IDLE;
      slot_q     <= ~CMD_RST_VERB[7];
      cnt_q      <= '0;
      need_q     <= '0;
      code_q     <= '0;
      overrun_q  <= 1'b0;
    end else begin
      if (word0_wr && !busy) begin
        cmd_verb_q <= cmd_wdata[7:0];
        cmd_pool_q <= cmd_wdata[15:8];
      end
      if (phase_flip && busy)
        overrun_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (commit) begin
          cnt_q  <= '0;
          need_q <= WORD_W'(dec_count);
          case (dec_kind)
            K_ACQ:   begin code_q <= OP_ACQ; state_q <= ST_REQ;  end
            K_QRY:   begin code_q <= OP_QRY; state_q <= ST_DONE; end
            default: begin code_q <= OP_BAD; state_q <= ST_DONE; end
          endcase
        end
        ST_REQ: if (pool_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (pool_gnt_valid) begin
          if (pool_gnt_err) begin
            code_q  <= OP_ECC;
            state_q <= ST_DONE;
          end else if (pool_gnt_empty) begin
            state_q <= ST_DONE;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= (cnt_q + 1'b1 == need_q) ? ST_DONE : ST_REQ;
          end
        end
        default: begin
          slot_q  <= ~slot_q;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  mcp_slots #(.ADDR_W(ADDR_W), .MAX_BUF(MAX_BUF)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (commit),
    .clr_slot (slot_q),
    .buf_we   (take_buf),
    .buf_slot (slot_q),
    .buf_idx  (IDX_W'(cnt_q)),
    .buf_addr (pool_gnt_addr),
    .fin_en   (state_q == ST_DONE),
    .fin_slot (slot_q),
    .fin_verb ({cmd_verb_q[7], code_q, 4'(cnt_q)}),
    .fin_pool (cmd_pool_q),
    .rd_slot  (rsp_slot),
    .rd_word  (rsp_word),
    .rd_data  (rsp_rdata),
    .verb_o   (slot_verbs)
  );

  assign pool_req_valid = (state_q == ST_REQ);
  assign pool_req_id    = cmd_pool_q[POOL_W-1:0];
  assign pool_gnt_ready = (state_q == ST_WAIT);
  assign overrun        = overrun_q;
endmodule

// File: rtl/mcp_chk.sv
`timescale 1ns/1ps
module mcp_chk #(
  parameter int MAX_BUF = 8,
  parameter int POOL_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              slot_q,
  input logic [1:0][7:0]   verbs,
  input logic              pool_req_valid,
  input logic              pool_req_ready,
  input logic [POOL_W-1:0] pool_req_id,
  input logic              pool_gnt_ready,
  input logic              overrun
);
  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_req_valid && !pool_req_ready |=> pool_req_valid && $stable(pool_req_id));

  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_gnt_ready |-> !pool_req_valid);

  // R4
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> verbs[slot_q] == 8'h00);

  // R3
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> slot_q != $past(slot_q));

  // R11
  other_slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(verbs[~slot_q]));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verbs[0][3:0] <= 4'(MAX_BUF) && verbs[1][3:0] <= 4'(MAX_BUF));
endmodule

bind mgmt_cmd_portal mcp_chk #(.MAX_BUF(MAX_BUF), .POOL_W(POOL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .slot_q         (slot_q),
  .verbs          (slot_verbs),
  .pool_req_valid (pool_req_valid),
  .pool_req_ready (pool_req_ready),
  .pool_req_id    (pool_req_id),
  .pool_gnt_ready (pool_gnt_ready),
  .overrun        (overrun)
);

// File: tb/test_mgmt_cmd_portal.sv
`timescale 1ns/1ps
module test_mgmt_cmd_portal;
  localparam int ERR_POOL = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [3:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_slot = 1'b0;
  logic [3:0]  rsp_word = '0;
  logic [31:0] rsp_rdata;
  logic        pool_req_valid, pool_gnt_ready, overrun;
  logic [5:0]  pool_req_id;
  logic        gnt_valid, gnt_empty, gnt_err;
  logic [31:0] gnt_addr;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mgmt_cmd_portal i_mgmt_cmd_portal (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_slot(rsp_slot), .rsp_word(rsp_word), .rsp_rdata(rsp_rdata),
    .pool_req_valid(pool_req_valid), .pool_req_ready(1'b1), .pool_req_id(pool_req_id),
    .pool_gnt_valid(gnt_valid), .pool_gnt_ready(pool_gnt_ready),
    .pool_gnt_empty(gnt_empty), .pool_gnt_err(gnt_err), .pool_gnt_addr(gnt_addr),
    .overrun(overrun)
  );

  function automatic int init_count(int p);
    if (p == 3) return 10;
    if (p == 7) return 2;
    return 4;
  endfunction

  // Pool agent stub
  int st_avail [64];
  int st_serial [64];
  int req_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 64; p++) begin
        st_avail[p]  <= init_count(p);
        st_serial[p] <= 0;
      end
      gnt_valid <= 1'b0; gnt_empty <= 1'b0; gnt_err <= 1'b0; gnt_addr <= '0;
      req_cnt <= 0;
    end else begin
      if (gnt_valid && pool_gnt_ready) gnt_valid <= 1'b0;
      if (pool_req_valid) begin
        req_cnt   <= req_cnt + 1;
        gnt_valid <= 1'b1;
        gnt_err   <= 1'b0;
        gnt_empty <= 1'b0;
        gnt_addr  <= '0;
        if (int'(pool_req_id) == ERR_POOL) gnt_err <= 1'b1;
        else if (st_avail[pool_req_id] == 0) gnt_empty <= 1'b1;
        else begin
          gnt_addr <= 32'hA000_0000 | (32'(pool_req_id) << 16) | 32'(st_serial[pool_req_id]);
          st_avail[pool_req_id]  <= st_avail[pool_req_id] - 1;
          st_serial[pool_req_id] <= st_serial[pool_req_id] + 1;
        end
      end
    end
  end

  // Reference model state
  int          m_avail [64];
  int          m_serial [64];
  logic        sw_phase = 1'b0;
  logic        m_slot = 1'b1;
  logic        exp_ov = 1'b0;
  logic [31:0] m_word0 [2] = '{32'h0, 32'h0};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] code, input logic [3:0] n,
                        input logic [7:0] pid, input string tag, input int inject);
    logic        ph;
    logic [2:0]  ecode;
    logic [31:0] fin, oth_val;
    logic [31:0] eaddr [8];
    int          edges, cnt, grants, rc0;
    ph = ~sw_phase;
    cnt = 0; grants = 0;
    for (int i = 0; i < 8; i++) eaddr[i] = '0;
    if (code == 3'h1 && n >= 1 && n <= 8 && pid < 64) begin
      if (int'(pid) == ERR_POOL) begin
        ecode = 3'h7; grants = 1;
      end else begin
        cnt = (m_avail[pid] < int'(n)) ? m_avail[pid] : int'(n);
        grants = (cnt < int'(n)) ? cnt + 1 : int'(n);
        for (int i = 0; i < cnt; i++)
          eaddr[i] = 32'hA000_0000 | (32'(pid) << 16) | 32'(m_serial[pid] + i);
        m_avail[pid]  -= cnt;
        m_serial[pid] += cnt;
        ecode = 3'h1;
      end
      edges = 2 * grants + 1;
    end else if (code == 3'h4 && pid < 64) begin
      ecode = 3'h4; edges = 1;
    end else begin
      ecode = 3'h6; edges = 1;
    end
    fin = {16'h0, pid, ph, ecode, 4'(cnt)};
    oth_val = m_word0[~m_slot];
    rc0 = req_cnt;

    @(negedge clk);
    rsp_slot = m_slot; rsp_word = 4'd0;
    cmd_we = 1'b1; cmd_addr = 4'd0; cmd_wdata = {16'h0, pid, ph, code, n};
    for (int j = 1; j <= edges + 1; j++) begin
      @(negedge clk);
      cmd_we = 1'b0;
      if (inject != 0 && j == inject + 1) exp_ov = 1'b1;
      if (inject != 0 && j == inject) begin
        cmd_we = 1'b1; cmd_wdata = {16'h0, 8'd1, ~ph, 3'h1, 4'h1};
      end
      #1;
      if (j == edges + 1) check({tag, " header"}, rsp_rdata, fin);
      else check({tag, " R4 header zero while pending"}, rsp_rdata, 32'h0);
      check({tag, " R10 overrun flag"}, 32'(overrun), 32'(exp_ov));
    end
    cmd_we = 1'b0;
    check({tag, " R12 pool requests"}, 32'(req_cnt - rc0), 32'(grants));
    for (int w = 1; w <= 8; w++) begin
      @(negedge clk);
      rsp_word = 4'(w);
      #1 check({tag, " R5/R6 payload word"}, rsp_rdata, eaddr[w-1]);
    end
    @(negedge clk);
    rsp_slot = ~m_slot; rsp_word = 4'd0;
    #1 check({tag, " R11 other slot kept"}, rsp_rdata, oth_val);
    m_word0[m_slot] = fin;
    m_slot = ~m_slot;
    sw_phase = ph;
  endtask

  task automatic same_phase_write();
    int rc0;
    @(negedge clk);
    rc0 = req_cnt;
    cmd_we = 1'b1; cmd_addr = 4'd0;
    cmd_wdata = {16'h0, 8'd3, sw_phase, 3'h1, 4'h2};
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 same phase no request", 32'(req_cnt), 32'(rc0));
    for (int s = 0; s < 2; s++) begin
      rsp_slot = 1'(s); rsp_word = 4'd0;
      #1 check("R2 same phase slots unchanged", rsp_rdata, m_word0[s]);
    end
  endtask

  initial begin
    for (int p = 0; p < 64; p++) begin
      m_avail[p] = init_count(p);
      m_serial[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 overrun low", 32'(overrun), 32'h0);
    check("R1 no request", 32'(pool_req_valid), 32'h0);
    rsp_slot = 1'b0; rsp_word = 4'd0;
    #1 check("R1 slot 0 header", rsp_rdata, 32'h0);
    rsp_slot = 1'b1;
    #1 check("R1 slot 1 header", rsp_rdata, 32'h0);

    do_cmd(3'h1, 4'd2, 8'd3,  "R2 R3 acquire two", 0);
    do_cmd(3'h4, 4'd0, 8'd5,  "R9 query", 0);
    do_cmd(3'h1, 4'd8, 8'd3,  "R5 acquire eight", 0);
    do_cmd(3'h1, 4'd3, 8'd7,  "R6 short pool", 0);
    do_cmd(3'h1, 4'd1, 8'd7,  "R6 empty pool", 0);
    do_cmd(3'h2, 4'd1, 8'd3,  "R7 bad code", 0);
    do_cmd(3'h1, 4'd0, 8'd3,  "R7 zero count", 0);
    do_cmd(3'h1, 4'd9, 8'd3,  "R7 count nine", 0);
    do_cmd(3'h1, 4'd1, 8'd64, "R7 pool id 64", 0);
    do_cmd(3'h1, 4'd4, 8'd9,  "R8 ecc", 0);
    same_phase_write();
    do_cmd(3'h1, 4'd3, 8'd4,  "R10 overrun during acquire", 2);
    do_cmd(3'h1, 4'd1, 8'd4,  "R10 after overrun", 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule